// File: doc/BRIEF.md
# PWM Prescaler Clock-Enable Generator

This block turns one master clock into a bank of clock-enable pulses for PWM channels. A free-running binary prescaler produces eleven enable taps. The fastest tap is active on every master cycle and the slowest on one cycle in 1024. Every tap is a single-cycle pulse in the master clock domain, so downstream counters keep running on the master clock and advance only when the enable they use is high.

Two independent linear dividers, A and B, each pick one prescaler tap and divide its pulse rate by an integer from 1 to 255. This gives two more enables. Software sets each divider through a small write port that carries a tap code and a divide value. A divide value of zero turns that divider's output off. A global enable input stands in for power gating of the master clock. While it is low, every output is silent and the prescaler phase is frozen.

Top module: `pwm_clkgen`

## Requirements
- R1: During reset and on the first cycle after it, every output is 0. Reset clears both dividers' tap code and divide value to 0, so `clka_en` and `clkb_en` stay 0 until a divider is written.
- R2: `tap_en[0]` is 1 on each cycle that follows a clock edge at which `mclk_en` was 1.
- R3: For k from 1 to 10, `tap_en[k]` pulses once every 2^k enabled cycles. Counting enabled edges since reset from 1, the pulse follows the edges whose count is a multiple of 2^k. A pulse on tap k always coincides with a pulse on tap k-1.
- R4: After an edge at which `mclk_en` is 0, every output is 0, the prescaler phase is held and neither divider advances. Counting resumes where it stopped.
- R5: When `cfg_we` is 1, the divider chosen by `cfg_sel` (0 = A, 1 = B) loads `cfg_tap` and `cfg_div` and restarts its count from zero. Its output is 0 on the following cycle, and a tap pulse present at the write edge is not counted.
- R6: With divide value d from 2 to 255, the divider output pulses together with every d-th output pulse of its selected tap after the write.
- R7: With divide value 1, the divider output copies its selected tap's output pulses.
- R8: With divide value 0, the divider output stays 0.
- R9: Tap codes 0 to 10 select `tap_en[code]`. Codes 11 to 15 select nothing, and the divider output stays 0.
- R10: Writing one divider does not change the output sequence of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_en | input | 1 | Global enable; low models a gated master clock |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Divider to write: 0 = A, 1 = B |
| cfg_tap | input | 4 | Prescaler tap code for the chosen divider |
| cfg_div | input | 8 | Divide value for the chosen divider (0 = off) |
| tap_en | output | 11 | Prescaler enable pulses, bit k at master/2^k |
| clka_en | output | 1 | Divider A enable pulse |
| clkb_en | output | 1 | Divider B enable pulse |

## Verification
The bench targets these corner cases and the faulty behaviour each one would expose:
- **Divide by 1.** A design that compares against d instead of d-1 would emit nothing or only every other pulse.
- **Divide by 255.** A divider counter that wraps early would give a short period.
- **Slowest tap, /1024.** A prescaler with a wrong tap mapping would give the wrong period.
- **Out-of-range tap codes and a divide value of zero.** A design without the guard would index past the tap bank or keep pulsing.
- **Disable window in mid-count.** A prescaler that keeps counting would resume with a shifted phase.
- **Rewrite in mid-count.** A divider that keeps its old count would emit an early, short first pulse.

Every observed output cycle is compared against a model built from the requirements.

// File: rtl/pwm_clkgen_pkg.sv
package pwm_clkgen_pkg;
  // Which linear divider a configuration write targets
  typedef enum logic {
    DIV_A = 1'b0,
    DIV_B = 1'b1
  } div_id_e;
  localparam int NUM_DIVS = 2;
endpackage

// File: rtl/pwm_prescaler.sv
// Free-running binary prescaler; produces combinational tap strobes
module pwm_prescaler #(
  parameter int PRE_BITS = 10,
  localparam int NUM_TAPS = PRE_BITS + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  output logic [NUM_TAPS-1:0] taps
);
  logic [PRE_BITS-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (run) phase <= phase + 1'b1;
  end

  assign taps[0] = run;

  // Tap k fires when the low k phase bits are all ones
  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
    assign taps[k] = run & (&phase[k-1:0]);
  end
endmodule

// File: rtl/pwm_lin_div.sv
// Linear divider: counts strobes of one selected tap, emits every d-th
module pwm_lin_div #(
  parameter int NUM_TAPS = 11,
  parameter int SEL_W    = 4,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [SEL_W-1:0]    sel_in,
  input  logic [DIV_W-1:0]    div_in,
  input  logic [NUM_TAPS-1:0] taps,
  output logic                pulse
);
  localparam logic [SEL_W-1:0] LAST_TAP = SEL_W'(NUM_TAPS - 1);

  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             src;
  logic             wrap;

  always_comb begin
    src = 1'b0;
    if (sel_q <= LAST_TAP) src = taps[sel_q];
  end

  assign wrap = (cnt_q == div_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (wr) begin
      sel_q <= sel_in;
      div_q <= div_in;
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (src && (div_q != '0)) begin
        if (wrap) begin
          cnt_q <= '0;
          pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_clkgen.sv
module pwm_clkgen
  import pwm_clkgen_pkg::*;
#(
  parameter int PRE_BITS = 10,
  parameter int SEL_W    = 4,
  parameter int DIV_W    = 8,
  localparam int NUM_TAPS = PRE_BITS + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mclk_en,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [SEL_W-1:0]    cfg_tap,
  input  logic [DIV_W-1:0]    cfg_div,
  output logic [NUM_TAPS-1:0] tap_en,
  output logic                clka_en,
  output logic                clkb_en
);
  logic [NUM_TAPS-1:0] taps_c;
  logic [NUM_DIVS-1:0] div_pulse;

  pwm_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (mclk_en),
    .taps (taps_c)
  );

  // Registered tap outputs line up with the divider output registers
  always_ff @(posedge clk) begin
    if (rst) tap_en <= '0;
    else     tap_en <= taps_c;
  end

  for (genvar d = 0; d < NUM_DIVS; d++) begin : g_div
    logic wr_d;
    assign wr_d = cfg_we && (cfg_sel == 1'(d));
    pwm_lin_div #(
      .NUM_TAPS (NUM_TAPS),
      .SEL_W    (SEL_W),
      .DIV_W    (DIV_W)
    ) u_div (
      .clk    (clk),
      .rst    (rst),
      .wr     (wr_d),
      .sel_in (cfg_tap),
      .div_in (cfg_div),
      .taps   (taps_c),
      .pulse  (div_pulse[d])
    );
  end

  assign clka_en = div_pulse[DIV_A];
  assign clkb_en = div_pulse[DIV_B];
endmodule

// File: rtl/pwm_clkgen_chk.sv
module pwm_clkgen_chk #(
  parameter int NUM_TAPS = 11
) (
  input logic                clk,
  input logic                rst,
  input logic                mclk_en,
  input logic                cfg_we,
  input logic                cfg_sel,
  input logic [NUM_TAPS-1:0] tap_en,
  input logic                clka_en,
  input logic                clkb_en
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (tap_en == '0) && !clka_en && !clkb_en);

  assert_full_rate_R2: assert property (@(posedge clk) disable iff (rst)
    mclk_en |=> tap_en[0]);

  assert_taps_nested_R3: assert property (@(posedge clk) disable iff (rst)
    (tap_en[NUM_TAPS-1:1] & ~tap_en[NUM_TAPS-2:0]) == '0);

  assert_gated_silent_R4: assert property (@(posedge clk) disable iff (rst)
    !mclk_en |=> (tap_en == '0) && !clka_en && !clkb_en);

  assert_write_restart_a_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_sel) |=> !clka_en);

  assert_write_restart_b_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel) |=> !clkb_en);

  // R6: a divider pulse always rides on a tap pulse, so never when gated
  assert_div_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
    (clka_en || clkb_en) |-> tap_en[0]);
endmodule

bind pwm_clkgen pwm_clkgen_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mclk_en (mclk_en),
  .cfg_we  (cfg_we),
  .cfg_sel (cfg_sel),
  .tap_en  (tap_en),
  .clka_en (clka_en),
  .clkb_en (clkb_en)
);

// File: tb/pwm_clkgen_bench.sv
`timescale 1ns/1ps
module pwm_clkgen_bench;
  localparam int NT = 11;
  localparam int NV = 8;
  // Vectors: divider, tap code, divide value, cycles to run
  localparam int V_CH [NV] = '{0, 0, 1, 0, 1, 0, 1, 0};
  localparam int V_TAP[NV] = '{0, 2, 3, 12, 1, 10, 0, 15};
  localparam int V_DIV[NV] = '{1, 5, 3, 4, 0, 2, 255, 1};
  localparam int V_LEN[NV] = '{20, 60, 80, 40, 30, 2100, 600, 30};

  logic clk = 1'b0;
  logic rst, mclk_en, cfg_we, cfg_sel;
  logic [3:0] cfg_tap;
  logic [7:0] cfg_div;
  logic [NT-1:0] tap_en;
  logic clka_en, clkb_en;

  int checks = 0;
  int failures = 0;

  // Model state derived from the requirements
  int n_en;
  int m_sel[2], m_div[2], m_cnt[2];
  logic [NT-1:0] exp_tap;
  logic exp_ab[2];

  always #4 clk = ~clk;

  pwm_clkgen u_pwm_clkgen (
    .clk(clk), .rst(rst), .mclk_en(mclk_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_tap(cfg_tap), .cfg_div(cfg_div),
    .tap_en(tap_en), .clka_en(clka_en), .clkb_en(clkb_en)
  );

  task automatic tick(input string tag);
    @(posedge clk);
    if (rst) begin
      n_en = 0;
      exp_tap = '0;
      for (int c = 0; c < 2; c++) begin
        m_sel[c] = 0; m_div[c] = 0; m_cnt[c] = 0; exp_ab[c] = 1'b0;
      end
    end else begin
      exp_tap = '0;
      if (mclk_en) begin
        for (int k = 0; k < NT; k++)
          exp_tap[k] = (((n_en + 1) % (1 << k)) == 0);
        n_en++;
      end
      for (int c = 0; c < 2; c++) begin
        exp_ab[c] = 1'b0;
        if (cfg_we && (int'(cfg_sel) == c)) begin
          m_sel[c] = int'(cfg_tap); m_div[c] = int'(cfg_div); m_cnt[c] = 0;
        end else if (m_sel[c] < NT && m_div[c] != 0 && exp_tap[m_sel[c]]) begin
          m_cnt[c]++;
          if (m_cnt[c] == m_div[c]) begin
            exp_ab[c] = 1'b1; m_cnt[c] = 0;
          end
        end
      end
    end
    @(negedge clk);
    checks++;
    if (tap_en[0] !== exp_tap[0]) begin
      failures++;
      $display("FAIL R2 tap0 actual=%b expected=%b", tap_en[0], exp_tap[0]);
    end else if (tap_en !== exp_tap) begin
      failures++;
      $display("FAIL R3 taps actual=%b expected=%b (%s)", tap_en, exp_tap, tag);
    end else if (clka_en !== exp_ab[0] || clkb_en !== exp_ab[1]) begin
      failures++;
      $display("FAIL %s a/b actual=%b%b expected=%b%b", tag, clka_en, clkb_en,
               exp_ab[0], exp_ab[1]);
    end
  endtask

  task automatic write_div(input int ch, input int tap, input int dv, input string tag);
    cfg_we = 1'b1; cfg_sel = ch[0]; cfg_tap = tap[3:0]; cfg_div = dv[7:0];
    tick(tag);
    cfg_we = 1'b0;
  endtask

  task automatic run(input int cyc, input string tag);
    for (int i = 0; i < cyc; i++) tick(tag);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; mclk_en = 1'b1; cfg_we = 1'b0; cfg_sel = 1'b0;
    cfg_tap = '0; cfg_div = '0;
    // R1: quiet during and after reset, dividers off by default
    run(3, "R1");
    rst = 1'b0;
    run(40, "R1");

    // Table walk; R6 general divide, R7 /1, R8 off, R9 bad code, R10 independence
    for (int v = 0; v < NV; v++) begin
      string tag;
      if (V_DIV[v] == 0)      tag = "R8";
      else if (V_TAP[v] > 10) tag = "R9";
      else if (V_DIV[v] == 1) tag = "R7";
      else if (V_CH[v] == 1)  tag = "R10";
      else                    tag = "R6";
      write_div(V_CH[v], V_TAP[v], V_DIV[v], "R5");
      run(V_LEN[v], tag);
    end

    // R4: gating freezes prescaler phase and dividers
    write_div(0, 1, 2, "R5");
    write_div(1, 3, 1, "R5");
    run(11, "R6");
    mclk_en = 1'b0;
    run(7, "R4");
    mclk_en = 1'b1;
    run(30, "R4");

    // R5: rewrite in mid-count restarts from zero
    write_div(0, 2, 4, "R5");
    run(9, "R5");
    write_div(0, 2, 4, "R5");
    run(25, "R5");

    // R1: reset in mid-run clears configuration
    rst = 1'b1;
    run(2, "R1");
    rst = 1'b0;
    run(30, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule